// File: doc/BRIEF.md
# Wormhole XY Mesh Routing Unit

This block sits behind one input port of a router in a two-dimensional mesh network-on-chip. It takes 8-bit flits from that input, keeps the first two flits of each packet as the header, and decides from them which of five router outputs the packet leaves on: the local port, east, west, north or south. The first header flit carries the target position, with X in the upper nibble and Y in the lower nibble. The second header flit carries the number of payload flits that follow.

The decision is dimension-ordered and always minimal. The packet travels along X until its column matches the router's own column. Only then does it travel along Y. A packet addressed to this router goes to the local port. The router's own coordinates come from static inputs, so one netlist serves every tile.

Once the chosen output is requested and granted, the block holds it for the whole packet. It sends the two stored header flits and then passes the payload flit by flit, each one moving as soon as the next stage can take it. Space for the whole packet is never needed. The output is freed after the last payload flit counted by the length field, and the block then accepts a new header. The crossbar and the arbitration between inputs are outside this block; a single grant input stands for them.

Top module: `wh_route_unit`

## Requirements
- R1: After reset, out_valid and req are 0 and in_ready is 1, so the block is ready for a new header.
- R2: req is one-hot with bit 0 = local, bit 1 = east, bit 2 = west, bit 3 = north, bit 4 = south. The route is taken from the first header flit: target X = bits 7:4, target Y = bits 3:0.
- R3: If target X is greater than here_x the request is east, and if it is smaller the request is west, whatever the Y values are. Only when the X values are equal does the block request north (target Y greater than here_y) or south (target Y smaller).
- R4: If target X equals here_x and target Y equals here_y, the request is local.
- R5: req goes high only after both header flits have been accepted. While req is high and grant has not yet been seen, out_valid and in_ready are 0. Forwarding starts in the cycle after grant is sampled high.
- R6: Under a grant the block emits, in order, the target flit, the length flit, and then exactly as many payload flits as the length field (0 to 255) gives. A length of 0 gives a two-flit packet.
- R7: When out_valid is 1 and out_ready is 0, out_valid stays 1 and out_flit keeps its value in the next cycle. No flit is lost or repeated under backpressure.
- R8: req keeps its value from the header until the last flit of the packet is transferred. In the next cycle req is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| here_x | input | 4 | X coordinate of this router (static) |
| here_y | input | 4 | Y coordinate of this router (static) |
| in_valid | input | 1 | Upstream flit present |
| in_flit | input | 8 | Upstream flit |
| in_ready | output | 1 | Block accepts the upstream flit this cycle |
| out_valid | output | 1 | Flit present toward the held output |
| out_flit | output | 8 | Flit toward the held output |
| out_ready | input | 1 | Next stage has room for one flit |
| req | output | 5 | One-hot output request, held for the packet |
| grant | input | 1 | Arbiter grants the requested output |

## Verification
The assertions check on every cycle that req is one-hot and respects the X-before-Y rule and the local case. They also check that forwarding begins only after a grant, that a stalled flit is held unchanged, that the request stays fixed for the packet, and that it drops right after the counted last flit. Only the bench's scenarios can show that the exact flit sequence arrives in order, with the right payload count including zero, for every target in a 4 by 4 mesh seen from several router positions. The bench runs these under random stalls on both sides and random grant delays, and also checks the reset state and the idle state after each packet.

// File: rtl/wh_route_pkg.sv
package wh_route_pkg;

  localparam int unsigned NUM_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FWD  = 2'd3
  } unit_state_e;

  typedef enum logic [1:0] {
    PH_DST  = 2'd0,
    PH_LEN  = 2'd1,
    PH_BODY = 2'd2
  } fwd_phase_e;

endpackage

// File: rtl/wh_hdr_regs.sv
module wh_hdr_regs #(
  parameter int unsigned FLIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_dst,
  input  logic              ld_len,
  input  logic [FLIT_W-1:0] din,
  output logic [FLIT_W-1:0] dst_q,
  output logic [FLIT_W-1:0] len_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      len_q <= '0;
    end else begin
      if (ld_dst) dst_q <= din;
      if (ld_len) len_q <= din;
    end
  end

endmodule

// File: rtl/wh_xy_route.sv
module wh_xy_route
  import wh_route_pkg::*;
#(
  parameter int unsigned COORD_W = 4
) (
  input  logic [COORD_W-1:0]   here_x,
  input  logic [COORD_W-1:0]   here_y,
  input  logic [2*COORD_W-1:0] dst,
  output logic [NUM_PORTS-1:0] port_oh
);

  function automatic port_e pick_port(
    input logic [COORD_W-1:0] hx,
    input logic [COORD_W-1:0] hy,
    input logic [COORD_W-1:0] tx,
    input logic [COORD_W-1:0] ty
  );
    port_e p;
    if (tx > hx)      p = PORT_EAST;
    else if (tx < hx) p = PORT_WEST;
    else if (ty > hy) p = PORT_NORTH;
    else if (ty < hy) p = PORT_SOUTH;
    else              p = PORT_LOCAL;
    return p;
  endfunction

  logic [COORD_W-1:0] tgt_x;
  logic [COORD_W-1:0] tgt_y;
  port_e              sel;

  assign tgt_x = dst[2*COORD_W-1:COORD_W];
  assign tgt_y = dst[COORD_W-1:0];
  assign sel   = pick_port(here_x, here_y, tgt_x, tgt_y);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_oh
    assign port_oh[g] = (sel == port_e'(g));
  end

endmodule

// File: rtl/wh_fwd_ctl.sv
module wh_fwd_ctl
  import wh_route_pkg::*;
#(
  parameter int unsigned FLIT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [FLIT_W-1:0]    in_flit,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [FLIT_W-1:0]    out_flit,
  input  logic                 out_ready,
  input  logic                 grant,
  input  logic [NUM_PORTS-1:0] route_oh,
  output logic [NUM_PORTS-1:0] req,
  input  logic [FLIT_W-1:0]    dst_q,
  input  logic [FLIT_W-1:0]    len_q,
  output logic                 ld_dst,
  output logic                 ld_len,
  output logic                 fwd_active,
  output logic                 xfer,
  output logic                 pkt_done
);

  unit_state_e       st_q;
  fwd_phase_e        ph_q;
  logic [FLIT_W-1:0] left_q;
  logic              hdr_phase;
  logic              last_hdr;
  logic              last_body;

  always_comb begin
    ld_dst     = (st_q == ST_IDLE) && in_valid;
    ld_len     = (st_q == ST_LEN) && in_valid;
    fwd_active = (st_q == ST_FWD);
    hdr_phase  = fwd_active && (ph_q != PH_BODY);
    out_valid  = fwd_active && (hdr_phase || in_valid);
    if (!fwd_active)           out_flit = '0;
    else if (ph_q == PH_DST)   out_flit = dst_q;
    else if (ph_q == PH_LEN)   out_flit = len_q;
    else                       out_flit = in_flit;
    in_ready   = (st_q == ST_IDLE) || (st_q == ST_LEN) ||
                 (fwd_active && (ph_q == PH_BODY) && out_ready);
    xfer       = out_valid && out_ready;
    last_hdr   = (ph_q == PH_LEN) && (len_q == '0);
    last_body  = (ph_q == PH_BODY) && (left_q == FLIT_W'(1));
    pkt_done   = xfer && (last_hdr || last_body);
    req        = ((st_q == ST_WAIT) || fwd_active) ? route_oh : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_DST;
      left_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_valid) st_q <= ST_LEN;
        ST_LEN:  if (in_valid) st_q <= ST_WAIT;
        ST_WAIT: if (grant) begin
          st_q <= ST_FWD;
          ph_q <= PH_DST;
        end
        ST_FWD: if (xfer) begin
          unique case (ph_q)
            PH_DST: ph_q <= PH_LEN;
            PH_LEN: begin
              if (len_q == '0) begin
                st_q <= ST_IDLE;
                ph_q <= PH_DST;
              end else begin
                ph_q   <= PH_BODY;
                left_q <= len_q;
              end
            end
            default: begin
              left_q <= left_q - FLIT_W'(1);
              if (left_q == FLIT_W'(1)) begin
                st_q <= ST_IDLE;
                ph_q <= PH_DST;
              end
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wh_route_unit.sv
module wh_route_unit
  import wh_route_pkg::*;
#(
  parameter int unsigned FLIT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FLIT_W/2-1:0]  here_x,
  input  logic [FLIT_W/2-1:0]  here_y,
  input  logic                 in_valid,
  input  logic [FLIT_W-1:0]    in_flit,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [FLIT_W-1:0]    out_flit,
  input  logic                 out_ready,
  output logic [NUM_PORTS-1:0] req,
  input  logic                 grant
);

  localparam int unsigned COORD_W = FLIT_W / 2;

  logic [FLIT_W-1:0]    hdr_dst;
  logic [FLIT_W-1:0]    hdr_len;
  logic                 ld_dst;
  logic                 ld_len;
  logic [NUM_PORTS-1:0] route_oh;
  logic                 fwd_active;
  logic                 xfer;
  logic                 pkt_done;

  wh_hdr_regs #(.FLIT_W(FLIT_W)) u_hdr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_dst (ld_dst),
    .ld_len (ld_len),
    .din    (in_flit),
    .dst_q  (hdr_dst),
    .len_q  (hdr_len)
  );

  wh_xy_route #(.COORD_W(COORD_W)) u_route (
    .here_x  (here_x),
    .here_y  (here_y),
    .dst     (hdr_dst),
    .port_oh (route_oh)
  );

  wh_fwd_ctl #(.FLIT_W(FLIT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_flit    (in_flit),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_ready  (out_ready),
    .grant      (grant),
    .route_oh   (route_oh),
    .req        (req),
    .dst_q      (hdr_dst),
    .len_q      (hdr_len),
    .ld_dst     (ld_dst),
    .ld_len     (ld_len),
    .fwd_active (fwd_active),
    .xfer       (xfer),
    .pkt_done   (pkt_done)
  );

endmodule

// File: rtl/wh_route_chk.sv
module wh_route_chk #(
  parameter int unsigned FLIT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [FLIT_W/2-1:0] here_x,
  input logic [FLIT_W/2-1:0] here_y,
  input logic [FLIT_W-1:0]   hdr_dst,
  input logic [4:0]          req,
  input logic                grant,
  input logic                out_valid,
  input logic                out_ready,
  input logic [FLIT_W-1:0]   out_flit,
  input logic                fwd_active,
  input logic                pkt_done
);

  localparam int unsigned CW = FLIT_W / 2;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req)); // R2

  AST_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((req != 5'd0) && (hdr_dst[FLIT_W-1:CW] != here_x)) |-> (req[1] || req[2])); // R3

  AST_LOCAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req != 5'd0) && (hdr_dst == {here_x, here_y})) |-> (req == 5'b00001)); // R4

  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_active) |-> $past(grant)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit))); // R7

  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((req != 5'd0) && fwd_active && !pkt_done) |=> $stable(req)); // R8

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> (req == 5'd0)); // R8

endmodule

bind wh_route_unit wh_route_chk #(.FLIT_W(FLIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .here_x     (here_x),
  .here_y     (here_y),
  .hdr_dst    (hdr_dst),
  .req        (req),
  .grant      (grant),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_flit   (out_flit),
  .fwd_active (fwd_active),
  .pkt_done   (pkt_done)
);

// File: tb/wh_route_unit_tb.sv
module wh_route_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] here_x = '0;
  logic [3:0] here_y = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_flit = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_flit;
  logic       out_ready = 1'b0;
  logic [4:0] req;
  logic       grant = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [7:0] exp_q [0:299];

  wh_route_unit u_dut (
    .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
    .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready),
    .req(req), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_req(input int mx, input int my, input int tx, input int ty);
    int dx = tx - mx;
    int dy = ty - my;
    if (dx > 0) return 5'b00010;
    if (dx < 0) return 5'b00100;
    if (dy > 0) return 5'b01000;
    if (dy < 0) return 5'b10000;
    return 5'b00001;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > MAX_CYC) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAX_CYC);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic run_packet(input int mx, input int my, input int tx, input int ty, input int cnt);
    int n = cnt + 2;
    int sidx = 0;
    int ridx = 0;
    bit seen_req = 0;
    bit got_grant = 0;
    bit early = 0;
    bit held = 0;
    logic [7:0] held_flit = '0;
    bit acc = 0;
    logic [4:0] er = expect_req(mx, my, tx, ty);
    here_x = 4'(mx);
    here_y = 4'(my);
    exp_q[0] = {4'(tx), 4'(ty)};
    exp_q[1] = 8'(cnt);
    for (int i = 0; i < cnt; i++) exp_q[i+2] = 8'((i * 37 + tx * 11 + ty + 5) & 255);
    while (ridx < n) begin
      @(negedge clk);
      if (acc) begin in_valid = 1'b0; acc = 0; end
      out_ready = ($urandom % 4) != 0;
      if (!in_valid && sidx < n && (($urandom % 3) != 0)) begin
        in_valid = 1'b1;
        in_flit  = exp_q[sidx];
      end
      if (req != 5'd0 && !grant && (($urandom % 2) != 0)) grant = 1'b1;
      #1;
      if (req != 5'd0 && !seen_req) begin
        seen_req = 1;
        // R2 R3 R4: output chosen by dimension order
        check(req == er, "R2/R3/R4 route", int'(req), int'(er));
      end
      if (!got_grant && (out_valid || (req != 5'd0 && in_ready))) early = 1;
      if (held) check(out_valid && out_flit == held_flit, "R7 stall hold", int'(out_flit), int'(held_flit));
      held = out_valid && !out_ready;
      held_flit = out_flit;
      if (in_valid && in_ready) begin sidx++; acc = 1; end
      if (out_valid && out_ready) begin
        check(out_flit == exp_q[ridx], "R6 flit order", int'(out_flit), int'(exp_q[ridx]));
        ridx++;
      end
      if (grant) got_grant = 1;
    end
    check(!early, "R5 no forwarding before grant", int'(early), 0);
    check(sidx == n, "R6 flits consumed", sidx, n);
    @(negedge clk);
    in_valid = 1'b0;
    grant = 1'b0;
    out_ready = 1'b0;
    #1;
    // R8: released right after the counted last flit
    check(req == 5'd0, "R8 release req", int'(req), 0);
    check(in_ready == 1'b1, "R8 idle ready", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(req == 5'd0, "R1 reset req", int'(req), 0);
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      int mx = (p == 0) ? 0 : (p == 1) ? 1 : (p == 2) ? 3 : 2;
      int my = (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 3 : 1;
      for (int tx = 0; tx < 4; tx++)
        for (int ty = 0; ty < 4; ty++)
          run_packet(mx, my, tx, ty, (tx * 3 + ty + mx) % 5);
    end
    run_packet(1, 1, 3, 0, 40);  // R6 long payload
    run_packet(2, 2, 2, 2, 0);   // R4 R6 local, header only
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule